// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of page mappings for 32-bit virtual addresses with 4 KB pages. A lookup presents a virtual address. The upper 20 bits, the virtual page number, are compared in parallel against every valid entry. One cycle later the block gives one of two results. On a hit it returns the matching 20-bit physical page number joined to the untouched 12-bit page offset. On a miss it raises a miss exception and supplies no address. The block does not walk page tables: software or a separate walker answers a miss by writing the mapping through the refill port.

Each entry has five fields: a valid flag, a dirty flag, a referenced flag, a virtual page tag and a physical page number. A hit of any kind marks its entry as referenced. A store that hits also marks its entry dirty. The response reports both flags as they stood before the access, so the state of an entry can be read at the ports.

A refill picks its target slot in this order:
1. an entry already holding the same virtual page;
2. otherwise the lowest-numbered empty entry;
3. otherwise a pseudo-random entry taken from a free-running 4-bit LFSR.

A flush input empties the whole buffer in one cycle, for use on a context switch.

The response side is a three-state machine. State IDLE means no result is pending. HIT_RSP presents a hit. MISS_RSP presents the miss exception. The transitions are as follows:
- From any state, a valid lookup moves the machine to HIT_RSP if some valid entry matched the page, and to MISS_RSP if none did.
- From any state, a cycle with no lookup moves the machine to IDLE.

Top module: `tlb_fa`

## Requirements
- R1: While reset is asserted, and after it is released, rsp_valid, rsp_hit and rsp_miss are 0 and every entry is empty, so the first lookup misses.
- R2: A lookup with lk_valid=1 at one rising edge gives rsp_valid=1 after that edge. On a hit, rsp_hit=1 and rsp_paddr = {stored physical page, lk_vaddr[11:0]}. The page number is lk_vaddr[31:12].
- R3: A lookup that finds no valid entry with an equal page gives rsp_miss=1, rsp_hit=0 and rsp_paddr=0. A cycle with no lookup gives rsp_valid=rsp_hit=rsp_miss=0.
- R4: A lookup with lk_write=1 that hits sets the entry's dirty flag. rsp_dirty shows the dirty flag of the hit entry as it was before that access, and is 0 on a miss.
- R5: Any hit sets the entry's referenced flag. rsp_ref shows that flag as it was before the access. A refill of an entry clears both its dirty and referenced flags.
- R6: A refill whose page already has a valid entry overwrites that entry. Otherwise it writes the lowest-indexed invalid entry. Otherwise it writes the entry whose index is the LFSR value modulo ENTRIES.
- R7: The LFSR is 4 bits wide and resets to 4'b0001. It advances on every clock edge out of reset as next = {q[2:0], q[3]^q[2]}, and the value held before the edge is the one used.
- R8: flush=1 at an edge empties every entry. A refill in the same cycle is discarded.
- R9: A lookup in the same cycle as a refill or flush is judged on the contents before that edge. If the refill targets the entry the lookup hit, the refill's clean flags win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a store |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Virtual page of the new mapping |
| fill_ppn | input | 20 | Physical page of the new mapping |
| flush | input | 1 | Empty all entries |
| rsp_valid | output | 1 | Result present for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Miss exception |
| rsp_paddr | output | 32 | Physical address, 0 on miss |
| rsp_dirty | output | 1 | Prior dirty flag of the hit entry |
| rsp_ref | output | 1 | Prior referenced flag of the hit entry |

## Verification
Two pairs of functions can land on one edge. A lookup can meet a refill that replaces the very entry it hits. A lookup can also meet a flush. The bench forces both pairs with directed steps, and the random phase also produces them by drawing pages from a small pool that keeps lookup and refill pages overlapping. Each outcome is judged against a bench model. The model computes the response from the contents before the edge. It then applies the hit's flag updates, and then the refill or flush, with the refill taking precedence. Follow-up lookups expose which mapping survived and its flag values.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned VA_W      = 32;
    localparam int unsigned OFF_W     = 12;
    localparam int unsigned VPN_W     = VA_W - OFF_W;
    localparam int unsigned PPN_W     = 20;
    localparam int unsigned PA_W      = PPN_W + OFF_W;
    localparam int unsigned RAND_W    = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIT   = 2'd1,
        ST_MISS  = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
    parameter int unsigned W = tlb_pkg::RAND_W
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd_q
);
    logic [W-1:0] rnd_d;

    always_comb begin
        rnd_d = {rnd_q[W-2:0], rnd_q[W-1] ^ rnd_q[W-2]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rnd_q <= {{(W-1){1'b0}}, 1'b1};
        else        rnd_q <= rnd_d;
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_q != '0) else $error("lfsr reached zero"); // R7
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int unsigned N    = 16,
    parameter int unsigned KW   = 20,
    localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         valid_i,
    input  logic [N-1:0][KW-1:0] tag_i,
    input  logic [KW-1:0]        key_i,
    output logic [N-1:0]         match_o,
    output logic                 hit_o,
    output logic [IDXW-1:0]      idx_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (tag_i[g] == key_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (match_o[i]) idx_o = idx_o | IDXW'(i);
        end
    end

    assign hit_o = |match_o;

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_o)) else $error("several entries match one page"); // R6
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int unsigned N    = 16,
    parameter int unsigned RW   = 4,
    localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fill_i,
    input  logic [N-1:0]    valid_i,
    input  logic            same_hit_i,
    input  logic [IDXW-1:0] same_idx_i,
    input  logic [RW-1:0]   rnd_i,
    output logic [IDXW-1:0] victim_o
);
    logic            any_free;
    logic [IDXW-1:0] free_idx;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                any_free = 1'b1;
                free_idx = IDXW'(i);
            end
        end
    end

    always_comb begin
        if (same_hit_i)    victim_o = same_idx_i;
        else if (any_free) victim_o = free_idx;
        else               victim_o = rnd_i[IDXW-1:0];
    end

    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !same_hit_i && !(&valid_i)) |-> !valid_i[victim_o])
        else $error("refill evicted a live entry while a free one existed"); // R6
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
    parameter int unsigned ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_valid,
    input  logic [31:0] lk_vaddr,
    input  logic        lk_write,
    input  logic        fill_valid,
    input  logic [19:0] fill_vpn,
    input  logic [19:0] fill_ppn,
    input  logic        flush,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic        rsp_miss,
    output logic [31:0] rsp_paddr,
    output logic        rsp_dirty,
    output logic        rsp_ref
);
    import tlb_pkg::*;

    localparam int unsigned IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]            valid_q, dirty_q, ref_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;

    logic [ENTRIES-1:0] lk_match, fl_match;
    logic               lk_hit, fl_same;
    logic [IDXW-1:0]    lk_idx, fl_same_idx, victim;
    logic [RAND_W-1:0]  rnd;

    rsp_state_e         state_q, state_d;
    logic [PPN_W-1:0]   r_ppn_q;
    logic [OFF_W-1:0]   r_off_q;
    logic               r_dirty_q, r_ref_q;

    tlb_lfsr #(.W(RAND_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_q (rnd)
    );

    tlb_cam #(.N(ENTRIES), .KW(VPN_W)) u_cam_lk (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_q),
        .tag_i   (vpn_q),
        .key_i   (lk_vaddr[VA_W-1:OFF_W]),
        .match_o (lk_match),
        .hit_o   (lk_hit),
        .idx_o   (lk_idx)
    );

    tlb_cam #(.N(ENTRIES), .KW(VPN_W)) u_cam_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_q),
        .tag_i   (vpn_q),
        .key_i   (fill_vpn),
        .match_o (fl_match),
        .hit_o   (fl_same),
        .idx_o   (fl_same_idx)
    );

    tlb_victim #(.N(ENTRIES), .RW(RAND_W)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_i     (fill_valid),
        .valid_i    (valid_q),
        .same_hit_i (fl_same),
        .same_idx_i (fl_same_idx),
        .rnd_i      (rnd),
        .victim_o   (victim)
    );

    // Entry storage: hit updates first, refill overrides, flush overrides all.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            ref_q   <= '0;
            vpn_q   <= '0;
            ppn_q   <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else begin
            if (lk_valid && lk_hit) begin
                ref_q[lk_idx] <= 1'b1;
                if (lk_write) dirty_q[lk_idx] <= 1'b1;
            end
            if (fill_valid) begin
                valid_q[victim] <= 1'b1;
                vpn_q[victim]   <= fill_vpn;
                ppn_q[victim]   <= fill_ppn;
                dirty_q[victim] <= 1'b0;
                ref_q[victim]   <= 1'b0;
            end
        end
    end

    // Response data captured from pre-edge contents.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_ppn_q   <= '0;
            r_off_q   <= '0;
            r_dirty_q <= 1'b0;
            r_ref_q   <= 1'b0;
        end else if (lk_valid) begin
            r_ppn_q   <= ppn_q[lk_idx];
            r_off_q   <= lk_vaddr[OFF_W-1:0];
            r_dirty_q <= dirty_q[lk_idx];
            r_ref_q   <= ref_q[lk_idx];
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (!lk_valid)   state_d = ST_IDLE;
        else if (lk_hit) state_d = ST_HIT;
        else             state_d = ST_MISS;
    end

    // Outputs from state.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_paddr = '0;
        rsp_dirty = 1'b0;
        rsp_ref   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_paddr = {r_ppn_q, r_off_q};
                rsp_dirty = r_dirty_q;
                rsp_ref   = r_ref_q;
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
            end
            default: ;
        endcase
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid) else $error("lookup gave no response"); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid) else $error("response without lookup"); // R3
    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_miss)) else $error("hit and miss together"); // R3
    AST_MISS_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == '0 && !rsp_dirty && !rsp_ref))
        else $error("miss carried an address"); // R3
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_miss || rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])))
        else $error("page offset altered"); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0)) else $error("flush left a valid entry"); // R8
    AST_STORE_DIRTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_write && lk_hit && !flush && !fill_valid) |=> dirty_q[$past(lk_idx)])
        else $error("store hit left entry clean"); // R4
endmodule

// File: tb/tlb_fa_bench.sv
module tlb_fa_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        fill_valid = 1'b0, flush = 1'b0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_dirty, rsp_ref;
    logic [31:0] rsp_paddr;

    always #2 clk = ~clk;

    tlb_fa #(.ENTRIES(N)) u_tlb_fa (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_paddr(rsp_paddr), .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    bit          m_v[N], m_d[N], m_r[N];
    logic [19:0] m_vpn[N], m_ppn[N];
    logic [3:0]  m_lfsr;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] lfsr_next(logic [3:0] q);
        return {q[2:0], q[3] ^ q[2]};   // R7
    endfunction

    function automatic int find(logic [19:0] vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic int pick_victim(logic [19:0] vpn);
        int s;
        s = find(vpn);
        if (s >= 0) return s;
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        return int'(m_lfsr) % N;   // R6
    endfunction

    task automatic step(bit lv, logic [31:0] va, bit wr, bit fv,
                        logic [19:0] fvpn, logic [19:0] fppn, bit fl, string tag);
        int hi, vic;
        bit e_d, e_r;
        logic [31:0] e_pa;
        lk_valid = lv; lk_vaddr = va; lk_write = wr;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; flush = fl;
        hi = lv ? find(va[31:12]) : -1;
        e_pa = (hi >= 0) ? {m_ppn[hi], va[11:0]} : 32'h0;
        e_d = (hi >= 0) ? m_d[hi] : 1'b0;
        e_r = (hi >= 0) ? m_r[hi] : 1'b0;
        vic = fv ? pick_victim(fvpn) : -1;
        if (fl) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end else begin
            if (hi >= 0) begin
                m_r[hi] = 1'b1;
                if (wr) m_d[hi] = 1'b1;
            end
            if (fv) begin
                m_v[vic] = 1'b1; m_vpn[vic] = fvpn; m_ppn[vic] = fppn;
                m_d[vic] = 1'b0; m_r[vic] = 1'b0;   // R5
            end
        end
        m_lfsr = lfsr_next(m_lfsr);
        @(posedge clk);
        @(negedge clk);
        if (lv) begin
            chk(rsp_valid == 1'b1, {"R2 valid ", tag}, 32'(rsp_valid), 32'd1);
            if (hi >= 0) begin
                chk(rsp_hit == 1'b1 && rsp_miss == 1'b0, {"R2 hit ", tag}, 32'(rsp_hit), 32'd1);
                chk(rsp_paddr == e_pa, {"R2 paddr ", tag}, rsp_paddr, e_pa);
                chk(rsp_dirty == e_d, {"R4 dirty ", tag}, 32'(rsp_dirty), 32'(e_d));
                chk(rsp_ref == e_r, {"R5 ref ", tag}, 32'(rsp_ref), 32'(e_r));
            end else begin
                chk(rsp_miss == 1'b1 && rsp_hit == 1'b0, {"R3 miss ", tag}, 32'(rsp_miss), 32'd1);
                chk(rsp_paddr == 32'h0, {"R3 paddr ", tag}, rsp_paddr, 32'h0);
            end
        end else begin
            chk(!rsp_valid && !rsp_hit && !rsp_miss, {"R3 idle ", tag}, 32'(rsp_valid), 32'd0);
        end
    endtask

    task automatic look(logic [19:0] vpn, logic [11:0] off, bit wr, string tag);
        step(1'b1, {vpn, off}, wr, 1'b0, 20'h0, 20'h0, 1'b0, tag);
    endtask

    task automatic fill(logic [19:0] vpn, logic [19:0] ppn, string tag);
        step(1'b0, 32'h0, 1'b0, 1'b1, vpn, ppn, 1'b0, tag);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_d[i] = 1'b0; m_r[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(!rsp_valid && !rsp_hit && !rsp_miss, "R1 in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        m_lfsr = 4'b0001;   // R7
        look(20'h12345, 12'habc, 1'b0, "R1 empty after reset");
        step(1'b0, 32'h0, 1'b0, 1'b0, 20'h0, 20'h0, 1'b0, "R3 no request");

        fill(20'h00010, 20'habcde, "R6 first free");
        look(20'h00010, 12'h123, 1'b0, "R2 first hit, R5 ref clear");
        look(20'h00010, 12'hfff, 1'b1, "R4 store hit");
        look(20'h00010, 12'h000, 1'b0, "R4 dirty now set");
        for (int i = 1; i < N; i++) fill(20'h00020 + 20'(i), 20'h70000 + 20'(i), "R6 free order");
        fill(20'h00010, 20'h13579, "R6 same page overwrite");
        look(20'h00010, 12'h456, 1'b0, "R5 refill cleans flags");
        fill(20'h00500, 20'h55555, "R7 random victim");
        look(20'h00010, 12'h001, 1'b0, "R7 survivor check");
        for (int i = 1; i < N; i++) look(20'h00020 + 20'(i), 12'h010, 1'b0, "R7 survivor check");
        look(20'h00500, 12'h002, 1'b0, "R7 new mapping");

        step(1'b1, {20'h00021, 12'h0aa}, 1'b1, 1'b1, 20'h00021, 20'h2468a, 1'b0, "R9 lookup with refill");
        look(20'h00021, 12'h0bb, 1'b0, "R9 refill wins flags");
        step(1'b1, {20'h00022, 12'h0cc}, 1'b0, 1'b1, 20'h00777, 20'h11111, 1'b1, "R8 flush with lookup and fill");
        look(20'h00022, 12'h0dd, 1'b0, "R8 emptied");
        look(20'h00777, 12'h0ee, 1'b0, "R8 fill discarded");

        for (int k = 0; k < 4000; k++) begin
            bit lv, fv, fl, wr;
            logic [19:0] lvpn, fvpn, fppn;
            lv   = ($urandom % 100) < 70;
            fv   = ($urandom % 100) < 30;
            fl   = ($urandom % 100) == 0;
            wr   = $urandom % 2;
            lvpn = 20'h00100 + 20'($urandom % 24);
            fvpn = 20'h00100 + 20'($urandom % 24);
            fppn = 20'($urandom);
            step(lv, {lvpn, 12'($urandom)}, wr, fv, fvpn, fppn, fl, "R9 random mix");
        end

        step(1'b0, 32'h0, 1'b0, 1'b0, 20'h0, 20'h0, 1'b0, "R3 final idle");
        done = 1'b1;
        finish_run();
    end
endmodule